// File: doc/BRIEF.md
# Trap Instruction Transformer

When a load, store or atomic access traps, the trap logic needs a cleaned-up copy of the faulting instruction to store in the trap-instruction register. This block produces that value. It takes the raw instruction word, the current register width, the address the access actually faulted on, the address the access started from, and a flag that marks a second-stage translation fault taken during a first-stage page-table walk. One cycle after a valid strobe it presents a registered, XLEN-wide transformed word.

Compressed memory instructions from quadrants 0 and 2 are rewritten into their 32-bit form, with the immediate removed and bit 1 cleared so software can still see that the original was 16 bits wide. Full-width memory instructions keep their opcode and registers but lose their immediates. The rs1 field of every result carries the byte offset between the faulting address and the start of the access. A fault taken during the page-table walk replaces the whole result with a fixed pseudoinstruction. Anything that is not a memory access yields zero.

Top module: `trap_insn_xform`

## Requirements
- R1: After reset `tinst_o` is zero. It loads a new value on the clock edge where `valid_i` is high, which is visible one cycle after the strobe, and holds that value while `valid_i` is low. Bits above 31 are always zero.
- R2: When `walk_fault_i` is set, the result is 0x00002000 for `xlen_i` = 2'b00 (32-bit) and 0x00003000 for every other `xlen_i` code (01 = 64-bit, 10 and 11 = 128-bit). All other inputs are ignored.
- R3: An instruction is compressed when bits [1:0] are not 2'b11, and bits [31:16] are then ignored. Bit 1 of a compressed result is 0. Quadrant 1 (bits [1:0] = 01) gives zero, as do funct3 (bits [15:13]) values 0 and 4 in quadrants 0 and 2.
- R4: Quadrant 0 (bits [1:0] = 00) uses register number 8 + bits [4:2]. This is rd (result bits [11:7]) for loads (funct3 1, 2, 3) and rs2 (result bits [24:20]) for stores (funct3 5, 6, 7).
- R5: Quadrant 2 (bits [1:0] = 10) takes rd from bits [11:7] for loads and rs2 from bits [6:2] for stores. The expanded opcodes are load 0x01, FP load 0x05, store 0x21 and FP store 0x25 (the 32-bit opcodes with bit 1 cleared). funct3 is 2 for word accesses and 3 for doubleword accesses. All immediate bits are zero.
- R6: Compressed funct3 2 and 6 are integer word accesses. funct3 3 and 7 are FP word accesses on 32-bit and integer doubleword accesses otherwise. funct3 1 and 5 are FP doubleword accesses on 32-bit and 64-bit, and give zero on 128-bit.
- R7: For a 32-bit LOAD (0x03) or FP-LOAD (0x07), the result is the instruction with bits [31:20] cleared. For STORE (0x23) or FP-STORE (0x27), bits [31:25] and [11:7] are cleared.
- R8: AMO (0x2F) and SYSTEM (0x73) with funct3 (bits [14:12]) = 4 pass through unchanged apart from rs1.
- R9: The rs1 field (bits [19:15]) holds the fault address minus the access address, clamped at 31. It is 0 when the fault address is below the access address.
- R10: The offset is masked to 2^k - 1, where k is the log2 of the access size: funct3[1:0] for LOAD and STORE, funct3 for FP-LOAD, FP-STORE and AMO, bits [27:26] for the SYSTEM form, and 2 or 3 for the compressed word or doubleword forms. When k is 5 or more, no masking is applied.
- R11: Any other 32-bit major opcode (bits [6:0]), and SYSTEM with funct3 other than 4, gives zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Capture strobe |
| insn_i | input | 32 | Raw trapping instruction |
| xlen_i | input | 2 | Register width code: 00 = 32, 01 = 64, 1x = 128 |
| walk_fault_i | input | 1 | Second-stage fault during a page-table walk |
| fault_addr_i | input | ADDR_W | Address that faulted |
| orig_addr_i | input | ADDR_W | Start address of the access |
| tinst_o | output | XLEN_MAX | Registered transformed instruction |

## Verification
The datapath is a single register stage, so a wrong decode or field placement shows up on `tinst_o` in the cycle right after the strobe. It appears as a misplaced register number, a leftover immediate bit, bit 1 still set, or a nonzero word where zero was expected. Errors in the offset path show up only in bits [19:15], and usually only at boundary distances: negative, beyond 31, or at the edge of the access-size mask. For that reason the distance is swept across those edges for every size. A wrong hold or reset shows up as `tinst_o` changing when no strobe was given.

// File: rtl/trap_xform_pkg.sv
package trap_xform_pkg;
  localparam int unsigned INSN_W  = 32;
  localparam int unsigned OFS_W   = 5;
  localparam int unsigned OFS_LSB = 15;

  localparam logic [1:0] XL32 = 2'd0;

  localparam logic [6:0] OPC_LOAD   = 7'h03;
  localparam logic [6:0] OPC_FLOAD  = 7'h07;
  localparam logic [6:0] OPC_STORE  = 7'h23;
  localparam logic [6:0] OPC_FSTORE = 7'h27;
  localparam logic [6:0] OPC_AMO    = 7'h2f;
  localparam logic [6:0] OPC_SYSTEM = 7'h73;
  localparam logic [2:0] F3_HYPMEM  = 3'd4;

  localparam logic [INSN_W-1:0] PSEUDO_RV32 = 32'h0000_2000;
  localparam logic [INSN_W-1:0] PSEUDO_WIDE = 32'h0000_3000;

  typedef struct packed {
    logic              hit;
    logic [2:0]        size_k;
    logic [INSN_W-1:0] body;
  } xform_t;

  function automatic logic is_rv32(input logic [1:0] xl);
    return xl == XL32;
  endfunction

  function automatic logic is_rv128(input logic [1:0] xl);
    return xl[1];
  endfunction
endpackage

// File: rtl/trap_xform_rvc.sv
module trap_xform_rvc
  import trap_xform_pkg::*;
(
  input  logic [15:0] c_insn_i,
  input  logic [1:0]  xlen_i,
  output xform_t      res_o
);
  logic [1:0] quad;
  logic [2:0] f3;
  logic [4:0] reg_ld, reg_st;
  logic       hit, is_fp, is_st, is_dbl, rv32, rv128;
  logic [6:0] opc;
  logic       unused_imm;

  assign unused_imm = c_insn_i[12];
  assign quad  = c_insn_i[1:0];
  assign f3    = c_insn_i[15:13];
  assign rv32  = is_rv32(xlen_i);
  assign rv128 = is_rv128(xlen_i);

  // quadrant 0 uses the 3-bit register window x8..x15
  assign reg_ld = (quad == 2'b00) ? {2'b01, c_insn_i[4:2]} : c_insn_i[11:7];
  assign reg_st = (quad == 2'b00) ? {2'b01, c_insn_i[4:2]} : c_insn_i[6:2];

  always_comb begin
    hit = 1'b0; is_fp = 1'b0; is_st = 1'b0; is_dbl = 1'b0;
    if (quad == 2'b00 || quad == 2'b10) begin
      case (f3)
        3'd1: begin hit = !rv128; is_fp = 1'b1; is_dbl = 1'b1; end
        3'd2: hit = 1'b1;
        3'd3: begin hit = 1'b1; is_fp = rv32; is_dbl = !rv32; end
        3'd5: begin hit = !rv128; is_fp = 1'b1; is_st = 1'b1; is_dbl = 1'b1; end
        3'd6: begin hit = 1'b1; is_st = 1'b1; end
        3'd7: begin hit = 1'b1; is_st = 1'b1; is_fp = rv32; is_dbl = !rv32; end
        default: ;
      endcase
    end
  end

  always_comb begin
    opc    = is_st ? OPC_STORE : OPC_LOAD;
    opc[2] = is_fp;
    res_o.hit    = hit;
    res_o.size_k = is_dbl ? 3'd3 : 3'd2;
    res_o.body   = '0;
    if (hit) begin
      res_o.body[6:0]   = opc;
      res_o.body[14:12] = is_dbl ? 3'd3 : 3'd2;
      if (is_st) res_o.body[24:20] = reg_st;
      else       res_o.body[11:7]  = reg_ld;
    end
  end
endmodule

// File: rtl/trap_xform_full.sv
module trap_xform_full
  import trap_xform_pkg::*;
(
  input  logic [INSN_W-1:0] insn_i,
  output xform_t            res_o
);
  logic [6:0] opc;
  logic [2:0] f3;

  assign opc = insn_i[6:0];
  assign f3  = insn_i[14:12];

  always_comb begin
    res_o = '0;
    case (opc)
      OPC_LOAD, OPC_FLOAD: begin
        res_o.hit          = 1'b1;
        res_o.size_k       = (opc == OPC_LOAD) ? {1'b0, f3[1:0]} : f3;
        res_o.body         = insn_i;
        res_o.body[31:20]  = '0;
      end
      OPC_STORE, OPC_FSTORE: begin
        res_o.hit          = 1'b1;
        res_o.size_k       = (opc == OPC_STORE) ? {1'b0, f3[1:0]} : f3;
        res_o.body         = insn_i;
        res_o.body[31:25]  = '0;
        res_o.body[11:7]   = '0;
      end
      OPC_AMO: begin
        res_o.hit    = 1'b1;
        res_o.size_k = f3;
        res_o.body   = insn_i;
      end
      OPC_SYSTEM: begin
        if (f3 == F3_HYPMEM) begin
          res_o.hit    = 1'b1;
          res_o.size_k = {1'b0, insn_i[27:26]};
          res_o.body   = insn_i;
        end
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/trap_xform_ofs.sv
module trap_xform_ofs
  import trap_xform_pkg::*;
#(
  parameter int unsigned ADDR_W = 64
) (
  input  logic [ADDR_W-1:0] fault_addr_i,
  input  logic [ADDR_W-1:0] orig_addr_i,
  input  logic [2:0]        size_k_i,
  output logic [OFS_W-1:0]  ofs_o
);
  logic [ADDR_W-1:0] diff;
  logic              below, big;
  logic [OFS_W-1:0]  sat, mask;

  assign diff  = fault_addr_i - orig_addr_i;
  assign below = fault_addr_i < orig_addr_i;
  assign big   = |diff[ADDR_W-1:OFS_W];
  // shifts of OFS_W or more leave the mask all ones
  assign mask  = ~({OFS_W{1'b1}} << size_k_i);
  assign sat   = below ? '0 : (big ? '1 : diff[OFS_W-1:0]);
  assign ofs_o = sat & mask;
endmodule

// File: rtl/trap_insn_xform.sv
module trap_insn_xform
  import trap_xform_pkg::*;
#(
  parameter int unsigned XLEN_MAX = 64,
  parameter int unsigned ADDR_W   = 64
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                valid_i,
  input  logic [31:0]         insn_i,
  input  logic [1:0]          xlen_i,
  input  logic                walk_fault_i,
  input  logic [ADDR_W-1:0]   fault_addr_i,
  input  logic [ADDR_W-1:0]   orig_addr_i,
  output logic [XLEN_MAX-1:0] tinst_o
);
  xform_t              rvc_res, full_res, sel;
  logic                is_cmp;
  logic [OFS_W-1:0]    ofs;
  logic [INSN_W-1:0]   word_d;
  logic [XLEN_MAX-1:0] tinst_d, tinst_q;

  trap_xform_rvc u_rvc (
    .c_insn_i (insn_i[15:0]),
    .xlen_i   (xlen_i),
    .res_o    (rvc_res)
  );

  trap_xform_full u_full (
    .insn_i (insn_i),
    .res_o  (full_res)
  );

  assign is_cmp = insn_i[1:0] != 2'b11;
  assign sel    = is_cmp ? rvc_res : full_res;

  trap_xform_ofs #(.ADDR_W(ADDR_W)) u_ofs (
    .fault_addr_i (fault_addr_i),
    .orig_addr_i  (orig_addr_i),
    .size_k_i     (sel.size_k),
    .ofs_o        (ofs)
  );

  always_comb begin
    word_d = '0;
    if (walk_fault_i) begin
      word_d = is_rv32(xlen_i) ? PSEUDO_RV32 : PSEUDO_WIDE;
    end else if (sel.hit) begin
      word_d = sel.body;
      word_d[OFS_LSB +: OFS_W] = ofs;
      if (is_cmp) word_d[1] = 1'b0;
    end
  end

  if (XLEN_MAX > INSN_W) begin : g_wide
    assign tinst_d = {{(XLEN_MAX-INSN_W){1'b0}}, word_d};
  end else begin : g_narrow
    assign tinst_d = word_d;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      tinst_q <= '0;
    else if (valid_i) tinst_q <= tinst_d;
  end

  assign tinst_o = tinst_q;
endmodule

// File: rtl/trap_xform_chk.sv
module trap_xform_chk #(
  parameter int unsigned XLEN_MAX = 64,
  parameter int unsigned ADDR_W   = 64
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                valid_i,
  input logic [31:0]         insn_i,
  input logic [1:0]          xlen_i,
  input logic                walk_fault_i,
  input logic [ADDR_W-1:0]   fault_addr_i,
  input logic [ADDR_W-1:0]   orig_addr_i,
  input logic [XLEN_MAX-1:0] tinst_o
);
  logic plain, known_op;
  assign plain    = valid_i && !walk_fault_i;
  assign known_op = insn_i[6:0] == 7'h03 || insn_i[6:0] == 7'h07 ||
                    insn_i[6:0] == 7'h23 || insn_i[6:0] == 7'h27 ||
                    insn_i[6:0] == 7'h2f ||
                    (insn_i[6:0] == 7'h73 && insn_i[14:12] == 3'd4);

  p_hold_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(tinst_o));
  p_upper_zero_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tinst_o >> 32) == '0);
  p_walk_rv32_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && walk_fault_i && xlen_i == 2'b00 |=> tinst_o == XLEN_MAX'(32'h2000));
  p_walk_wide_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && walk_fault_i && xlen_i != 2'b00 |=> tinst_o == XLEN_MAX'(32'h3000));
  p_cmp_bit1_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    plain && insn_i[1:0] != 2'b11 |=> !tinst_o[1]);
  p_q1_zero_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    plain && insn_i[1:0] == 2'b01 |=> tinst_o == '0);
  p_neg_ofs_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    plain && fault_addr_i < orig_addr_i |=> tinst_o[19:15] == 5'd0);
  p_unknown_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    plain && insn_i[1:0] == 2'b11 && !known_op |=> tinst_o == '0);
endmodule

bind trap_insn_xform trap_xform_chk #(.XLEN_MAX(XLEN_MAX), .ADDR_W(ADDR_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .valid_i      (valid_i),
  .insn_i       (insn_i),
  .xlen_i       (xlen_i),
  .walk_fault_i (walk_fault_i),
  .fault_addr_i (fault_addr_i),
  .orig_addr_i  (orig_addr_i),
  .tinst_o      (tinst_o)
);

// File: tb/trap_insn_xform_tb_top.sv
`timescale 1ns/1ps
module trap_insn_xform_tb_top;
  localparam int unsigned XW = 64;
  localparam int unsigned AW = 64;
  localparam time HALF = 10ns;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          valid = 1'b0;
  logic [31:0]   insn = '0;
  logic [1:0]    xlen = '0;
  logic          wf = 1'b0;
  logic [AW-1:0] fa = '0, oa = '0;
  logic [XW-1:0] tinst;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #HALF clk = ~clk;

  trap_insn_xform #(.XLEN_MAX(XW), .ADDR_W(AW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .insn_i(insn), .xlen_i(xlen),
    .walk_fault_i(wf), .fault_addr_i(fa), .orig_addr_i(oa), .tinst_o(tinst)
  );

  task automatic chk(input string tg, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tg, act, exp);
    end
  endtask

  function automatic logic [63:0] ofs_ref(input logic [63:0] f, input logic [63:0] o,
                                          input int k);
    logic [63:0] d;
    logic [63:0] m;
    if (f < o) return 0;
    d = f - o;
    if (d > 31) d = 31;
    m = (k >= 5) ? 64'd31 : (64'd1 << k) - 1;
    return d & m;
  endfunction

  function automatic logic [63:0] model(input logic [31:0] i, input logic [1:0] xl,
                                        input logic w, input logic [63:0] f,
                                        input logic [63:0] o, output string tg);
    logic [63:0] r;
    int k;
    if (w) begin
      tg = "R2";
      return (xl == 2'b00) ? 64'h2000 : 64'h3000;
    end
    if (i[1:0] != 2'b11) begin
      bit ok, fp, st, wide, rv32, rv128;
      logic [63:0] opc, rg;
      rv32 = (xl == 2'b00); rv128 = xl[1];
      ok = 0; fp = 0; st = 0; wide = 0;
      case (i[15:13])
        3'd1: if (!rv128) begin ok = 1; fp = 1; wide = 1; end
        3'd2: ok = 1;
        3'd3: begin ok = 1; if (rv32) fp = 1; else wide = 1; end
        3'd5: if (!rv128) begin ok = 1; fp = 1; st = 1; wide = 1; end
        3'd6: begin ok = 1; st = 1; end
        3'd7: begin ok = 1; st = 1; if (rv32) fp = 1; else wide = 1; end
        default: ok = 0;
      endcase
      if (i[1:0] == 2'b01) ok = 0;
      if (!ok) begin
        tg = (i[1:0] == 2'b01 || i[15:13] == 0 || i[15:13] == 4) ? "R3" : "R6";
        return 0;
      end
      tg = i[13] ? "R6" : (i[1:0] == 2'b00 ? "R4" : "R5");
      k = wide ? 3 : 2;
      opc = 64'h03 + (st ? 64'h20 : 0) + (fp ? 64'h04 : 0);
      opc = opc & ~64'h2;
      if (i[1:0] == 2'b00) rg = 8 + 64'(i[4:2]);
      else rg = st ? 64'(i[6:2]) : 64'(i[11:7]);
      r = opc | (64'(k) << 12) | (st ? (rg << 20) : (rg << 7));
      return r | (ofs_ref(f, o, k) << 15);
    end
    case (i[6:0])
      7'h03, 7'h07: begin
        tg = "R7";
        k = (i[6:0] == 7'h03) ? int'(i[13:12]) : int'(i[14:12]);
        r = 64'(i) & ~(64'hfff << 20);
      end
      7'h23, 7'h27: begin
        tg = "R7";
        k = (i[6:0] == 7'h23) ? int'(i[13:12]) : int'(i[14:12]);
        r = 64'(i) & ~((64'h7f << 25) | (64'h1f << 7));
      end
      7'h2f: begin tg = "R8"; k = int'(i[14:12]); r = 64'(i); end
      7'h73: begin
        if (i[14:12] != 3'd4) begin tg = "R11"; return 0; end
        tg = "R8"; k = int'(i[27:26]); r = 64'(i);
      end
      default: begin tg = "R11"; return 0; end
    endcase
    r = r & ~(64'h1f << 15);
    return r | (ofs_ref(f, o, k) << 15);
  endfunction

  logic [63:0] last_exp;

  task automatic apply(input logic [31:0] i, input logic [1:0] xl, input logic w,
                       input logic [63:0] f, input logic [63:0] o, input string force_tg);
    string tg;
    logic [63:0] e;
    e = model(i, xl, w, f, o, tg);
    if (force_tg != "") tg = force_tg;
    @(negedge clk);
    insn = i; xlen = xl; wf = w; fa = f; oa = o; valid = 1'b1;
    @(negedge clk);
    valid = 1'b0;
    chk(tg, tinst, e);
    last_exp = e;
  endtask

  function automatic logic [63:0] rnd_ofs_fault(input logic [63:0] base);
    int d;
    d = int'($urandom_range(44)) - 4;
    return base + 64'(signed'(d));
  endfunction

  initial begin
    #(HALF * 2 * 190000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [63:0] base;
    logic [31:0] r;
    logic [6:0] ops [10];
    ops = '{7'h03, 7'h07, 7'h23, 7'h27, 7'h2f, 7'h73, 7'h33, 7'h13, 7'h6f, 7'h0b};

    repeat (3) @(negedge clk);
    chk("R1 reset", tinst, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 idle", tinst, 64'd0);

    // R2 walk fault: every width code, arbitrary instruction
    for (int x = 0; x < 4; x++)
      for (int n = 0; n < 4; n++) begin
        base = {$urandom(), $urandom()};
        apply($urandom(), 2'(x), 1'b1, rnd_ofs_fault(base), base, "");
      end

    // R3..R6 compressed sweep
    for (int x = 0; x < 4; x++)
      for (int q = 0; q < 3; q++)
        for (int f = 0; f < 8; f++)
          for (int n = 0; n < 24; n++) begin
            r = $urandom();
            r[15:13] = 3'(f);
            r[1:0] = 2'(q);
            base = {$urandom(), $urandom()};
            apply(r, 2'(x), 1'b0, rnd_ofs_fault(base), base, "");
          end

    // R7, R8, R11 full-width sweep
    for (int p = 0; p < 10; p++)
      for (int f = 0; f < 8; f++)
        for (int n = 0; n < 12; n++) begin
          r = $urandom();
          r[6:0] = ops[p];
          r[14:12] = 3'(f);
          base = {$urandom(), $urandom()};
          apply(r, 2'($urandom_range(3)), 1'b0, rnd_ofs_fault(base), base, "");
        end

    // R9 distance sweep on a doubleword load, including negative and saturating
    for (int d = -3; d < 40; d++) begin
      base = 64'hffff_ffff_ffff_ff00 - 64'(d * 3);
      apply(32'h0000_3003 | (32'($urandom_range(31)) << 7), 2'b01, 1'b0,
            base + 64'(signed'(d)), base, "R9");
    end
    // R9 huge distance saturates then masks
    apply(32'h0040_2f2f, 2'b01, 1'b0, 64'h8000_0000_0000_0000, 64'h10, "R9");

    // R10 mask per access size: distance 31 exposes the mask
    for (int f = 0; f < 8; f++) begin
      apply({17'h0, 3'(f), 12'h003}, 2'b01, 1'b0, 64'h1000 + 31, 64'h1000, "R10");
      apply({17'h0, 3'(f), 12'h027}, 2'b01, 1'b0, 64'h1000 + 31, 64'h1000, "R10");
      apply({17'h0, 3'(f), 12'h02f}, 2'b01, 1'b0, 64'h1000 + 29, 64'h1000, "R10");
    end
    for (int s = 0; s < 4; s++)
      apply({4'b0110, 2'(s), 11'h0, 3'd4, 12'h073}, 2'b00, 1'b0, 64'd47, 64'd16, "R10");
    apply(32'h0000_4004, 2'b00, 1'b0, 64'd31, 64'd0, "R10");
    apply(32'h0000_6006, 2'b01, 1'b0, 64'd31, 64'd0, "R10");

    // R1 hold while valid is low
    apply(32'h0081_3083, 2'b01, 1'b0, 64'd5, 64'd0, "R1");
    @(negedge clk);
    insn = 32'h0000_2000; wf = 1'b1; xlen = 2'b00;
    repeat (2) @(negedge clk);
    chk("R1 hold", tinst, last_exp);

    // R1 asynchronous reset clears a held value
    rst_n = 1'b0;
    #1;
    chk("R1 async reset", tinst, 64'd0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after reset", tinst, 64'd0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule